// File: doc/BRIEF.md
# VCO Acquisition Sweep Controller

This block steers the tuning code of a voltage-controlled oscillator while a serial video receiver hunts for lock. While a carrier is present and no timing-reference activity is reported by the downstream decoder, it walks the code downward on every sweep tick. A lower code means a higher oscillator frequency. When the code would pass its floor, it jumps back to the ceiling, so the output forms a repeating sawtooth. An external DAC turns the code into the analog tuning voltage.

Timing-reference activity arrives as a level that flips each time a reference word is decoded. Any flip within the last `TRS_TIMEOUT` clocks counts as activity, and activity freezes the code. If carrier is lost, the code is held where it is, so that relock is quick when data returns. A modulus bit, which selects the oscillator's divide-by-two path, flips on every second sweep wrap. A rate detector can force that bit. A forced value that differs from the current one also restarts the sweep from the ceiling.

Top module: `vco_sweep_ctrl`

## Requirements
- R1: After reset, `code_o` equals `CODE_MAX` and `modulus_o` is 0.
- R2: With `carrier_i` high, no timing-reference activity, and `sweep_tick_i` high, `code_o` decreases by `STEP` one clock later, provided the result stays at or above `CODE_MIN`.
- R3: A tick that would take `code_o` below `CODE_MIN` loads `CODE_MAX` instead (a wrap). `code_o` never leaves the range `CODE_MIN..CODE_MAX`.
- R4: In a clock without `sweep_tick_i`, `code_o` does not change, unless a force restart occurs.
- R5: A change of level on `trs_toggle_i` makes the block report activity from the next clock. It also reloads a window of `TRS_TIMEOUT` clocks. While activity is reported, ticks leave `code_o` unchanged.
- R6: Once `TRS_TIMEOUT` clocks pass without a further change on `trs_toggle_i`, ticks move `code_o` again.
- R7: While `carrier_i` is low, `code_o` and `modulus_o` keep their values, whatever the ticks do.
- R8: Without a force, `modulus_o` inverts on every second wrap, counted from reset or from the last force restart. It changes at no other time.
- R9: When `force_en_i` is high and `force_val_i` differs from `modulus_o`, one clock later `modulus_o` equals `force_val_i` and `code_o` equals `CODE_MAX`. Reported activity is also cleared, and the wrap count starts again from zero.
- R10: While `force_en_i` is high, `modulus_o` equals `force_val_i` and wraps do not toggle it. The sweep itself still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| carrier_i | input | 1 | Serial carrier present |
| trs_toggle_i | input | 1 | Level that flips on each decoded timing-reference word (already synchronized) |
| sweep_tick_i | input | 1 | One-clock sweep step enable |
| force_en_i | input | 1 | Rate detector overrides the modulus bit |
| force_val_i | input | 1 | Forced modulus value |
| code_o | output | CODE_W | Tuning code for the DAC |
| modulus_o | output | 1 | Oscillator divide-by-two select |

## Verification
The bench builds the block with `CODE_MAX`=40, `CODE_MIN`=4, `STEP`=3 and `TRS_TIMEOUT`=20. A ramp therefore wraps every 13 ticks, and a modulus flip needs only 26 ticks. The activity window also expires in a few dozen clocks. With these values, the random phase hits wraps, window expiry, carrier drops and force restarts many times, including cases where several of them fall in the same clock.

// File: rtl/sweep_pkg.sv
// Package: shared types for the acquisition sweep controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sweep_pkg;

    // Operating mode chosen each clock from carrier and reference activity.
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,   // no carrier: code frozen for quick relock
        MODE_SWEEP  = 2'd1,   // carrier, no reference activity: ramp runs
        MODE_FROZEN = 2'd2    // reference activity present: lock kept
    } sweep_mode_e;

endpackage

// File: rtl/sweep_trs_monitor.sv
// Module: sweep_trs_monitor
// Watches a level that flips on each decoded reference word.
// busy_o is high while a flip has been seen within the last TIMEOUT
// clocks. clear_i empties the window at once.
// Assumes toggle_i is already in the clk domain. Its reset image is 0.
module sweep_trs_monitor #(
    parameter int TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic clear_i,
    output logic busy_o
);
    localparam int             TW    = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0]  TLOAD = TW'(TIMEOUT);

    logic          toggle_q;
    logic [TW-1:0] window_q;
    logic          flip;

    // Detect any change of level against the previous clock.
    assign flip = toggle_i ^ toggle_q;

    // Track the previous level of the toggle input.
    always_ff @(posedge clk) begin
        if (!rst_n) toggle_q <= 1'b0;
        else        toggle_q <= toggle_i;
    end

    // Reload the window on a flip and count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 window_q <= '0;
        else if (clear_i)           window_q <= '0;
        else if (flip)              window_q <= TLOAD;
        else if (window_q != '0)    window_q <= window_q - 1'b1;
    end

    assign busy_o = (window_q != '0);
endmodule

// File: rtl/sweep_ramp.sv
// Module: sweep_ramp
// Down-counting sawtooth between CODE_MAX and CODE_MIN in steps of STEP.
// A step that would go below CODE_MIN reloads CODE_MAX and raises wrap_o.
// Assumes CODE_MIN + STEP <= CODE_MAX < 2**CODE_W. step_i and restart_i
// are never high together.
module sweep_ramp #(
    parameter int CODE_W   = 12,
    parameter int CODE_MAX = 4000,
    parameter int CODE_MIN = 64,
    parameter int STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              restart_i,
    output logic [CODE_W-1:0] code_o,
    output logic              wrap_o
);
    localparam logic [CODE_W-1:0] CEIL  = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CODE_MIN + STEP);
    localparam logic [CODE_W-1:0] DELTA = CODE_W'(STEP);

    logic [CODE_W-1:0] code_q;

    // A wrap happens on a step taken from below the last legal step point.
    assign wrap_o = step_i && (code_q < LIMIT);

    // Hold, step down, wrap to the ceiling or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= CEIL;
        else if (restart_i) code_q <= CEIL;
        else if (wrap_o)    code_q <= CEIL;
        else if (step_i)    code_q <= code_q - DELTA;
    end

    assign code_o = code_q;
endmodule

// File: rtl/sweep_modulus.sv
// Module: sweep_modulus
// Modulus bit that flips on every second wrap of the ramp, so it runs at a
// quarter of the sweep rate. An override forces the bit. A forced value
// that differs from the current bit raises restart_o and clears the wrap parity.
// Assumes wrap_i is a single-clock pulse.
module sweep_modulus (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic force_en_i,
    input  logic force_val_i,
    output logic mod_o,
    output logic restart_o
);
    logic mod_q;
    logic parity_q;

    // Flag a forced value that disagrees with the present bit.
    assign restart_o = force_en_i && (force_val_i != mod_q);

    // Update the bit from the override or from every second wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q    <= 1'b0;
            parity_q <= 1'b0;
        end else if (force_en_i) begin
            mod_q <= force_val_i;
            if (restart_o) parity_q <= 1'b0;
        end else if (wrap_i) begin
            parity_q <= ~parity_q;
            if (parity_q) mod_q <= ~mod_q;
        end
    end

    assign mod_o = mod_q;
endmodule

// File: rtl/vco_sweep_ctrl.sv
// Module: vco_sweep_ctrl (top)
// Acquisition sweep controller. It ramps a tuning code while carrier is
// present and no reference activity is seen, freezes the code on activity,
// holds it on carrier loss, and derives a modulus bit from the ramp wraps.
// Assumes all inputs are synchronous to clk.
module vco_sweep_ctrl #(
    parameter int CODE_W      = 12,
    parameter int CODE_MAX    = 4000,
    parameter int CODE_MIN    = 64,
    parameter int STEP        = 4,
    parameter int TRS_TIMEOUT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_i,
    input  logic              trs_toggle_i,
    input  logic              sweep_tick_i,
    input  logic              force_en_i,
    input  logic              force_val_i,
    output logic [CODE_W-1:0] code_o,
    output logic              modulus_o
);
    import sweep_pkg::*;

    sweep_mode_e mode;
    logic        trs_busy;
    logic        restart;
    logic        step;
    logic        wrap;

    // Choose the operating mode from carrier and reference activity.
    always_comb begin
        if (!carrier_i)    mode = MODE_HOLD;
        else if (trs_busy) mode = MODE_FROZEN;
        else               mode = MODE_SWEEP;
    end

    // Step only when sweeping, ticked, and not restarting.
    assign step = (mode == MODE_SWEEP) && sweep_tick_i && !restart;

    sweep_trs_monitor #(
        .TIMEOUT (TRS_TIMEOUT)
    ) u_trs (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (trs_toggle_i),
        .clear_i  (restart),
        .busy_o   (trs_busy)
    );

    sweep_ramp #(
        .CODE_W   (CODE_W),
        .CODE_MAX (CODE_MAX),
        .CODE_MIN (CODE_MIN),
        .STEP     (STEP)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .code_o    (code_o),
        .wrap_o    (wrap)
    );

    sweep_modulus u_mod (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_i      (wrap),
        .force_en_i  (force_en_i),
        .force_val_i (force_val_i),
        .mod_o       (modulus_o),
        .restart_o   (restart)
    );
endmodule

// File: rtl/vco_sweep_ctrl_chk.sv
// Module: vco_sweep_ctrl_chk
// Property checker bound to vco_sweep_ctrl. It watches ports and the
// activity flag that the monitor hands to the mode logic.
module vco_sweep_ctrl_chk #(
    parameter int CODE_W   = 12,
    parameter int CODE_MAX = 4000,
    parameter int CODE_MIN = 64,
    parameter int STEP     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              carrier_i,
    input logic              sweep_tick_i,
    input logic              force_en_i,
    input logic              force_val_i,
    input logic              trs_busy,
    input logic [CODE_W-1:0] code_o,
    input logic              modulus_o
);
    localparam logic [CODE_W-1:0] CEIL  = CODE_W'(CODE_MAX);
    localparam logic [CODE_W-1:0] FLOOR = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CODE_MIN + STEP);
    localparam logic [CODE_W-1:0] DELTA = CODE_W'(STEP);

    logic mism;
    assign mism = force_en_i && (force_val_i != modulus_o);

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o >= FLOOR) && (code_o <= CEIL)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_i && sweep_tick_i && !trs_busy && !mism && code_o >= LIMIT)
        |=> (code_o == $past(code_o) - DELTA)); // R2
    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweep_tick_i && !mism) |=> $stable(code_o)); // R4
    AST_FROZEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (trs_busy && !mism) |=> $stable(code_o)); // R5
    AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_i && !force_en_i) |=> ($stable(code_o) && $stable(modulus_o))); // R7
    AST_MOD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !force_en_i |=> ($stable(modulus_o) || (code_o == CEIL))); // R8
    AST_FORCE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mism |=> (code_o == CEIL)); // R9
    AST_FORCE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        force_en_i |=> (modulus_o == $past(force_val_i))); // R10
endmodule

bind vco_sweep_ctrl vco_sweep_ctrl_chk #(
    .CODE_W   (CODE_W),
    .CODE_MAX (CODE_MAX),
    .CODE_MIN (CODE_MIN),
    .STEP     (STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_i    (carrier_i),
    .sweep_tick_i (sweep_tick_i),
    .force_en_i   (force_en_i),
    .force_val_i  (force_val_i),
    .trs_busy     (trs_busy),
    .code_o       (code_o),
    .modulus_o    (modulus_o)
);

// File: tb/tb_vco_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_vco_sweep_ctrl;
    localparam int W   = 8;
    localparam int MAX = 40;
    localparam int MIN = 4;
    localparam int STP = 3;
    localparam int TO  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier = 1'b0, hs = 1'b0, tick = 1'b0, fe = 1'b0, fv = 1'b0;
    logic [W-1:0] code;
    logic mod_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    int m_code, m_mod, m_par, m_timer, m_hs;

    always #2 clk = ~clk;

    vco_sweep_ctrl #(
        .CODE_W(W), .CODE_MAX(MAX), .CODE_MIN(MIN), .STEP(STP), .TRS_TIMEOUT(TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .trs_toggle_i(hs),
        .sweep_tick_i(tick), .force_en_i(fe), .force_val_i(fv),
        .code_o(code), .modulus_o(mod_out)
    );

    // Next code for one tick according to the ramp rule
    function automatic int ramp_next(int c);
        return (c - STP < MIN) ? MAX : c - STP;
    endfunction

    // Reference model advanced at each rising edge from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = MAX; m_mod = 0; m_par = 0; m_timer = 0; m_hs = 0;
        end else if (fe && (int'(fv) != m_mod)) begin
            m_mod = fv; m_code = MAX; m_par = 0; m_timer = 0; m_hs = hs;
        end else begin
            bit stp, wr;
            stp = carrier && (m_timer == 0) && tick;
            wr  = stp && (m_code - STP < MIN);
            if (stp) m_code = ramp_next(m_code);
            if (fe) m_mod = fv;
            else if (wr) begin
                if (m_par == 1) m_mod = 1 - m_mod;
                m_par = 1 - m_par;
            end
            if (int'(hs) != m_hs) m_timer = TO;
            else if (m_timer > 0) m_timer = m_timer - 1;
            m_hs = hs;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_cycle(bit t);
        tick = t;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step_cycle(1'b1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code", code, MAX);
        chk("R1 modulus", mod_out, 0);

        carrier = 1;
        step_cycle(1);
        chk("R2 one step", code, 37);
        repeat (4) step_cycle(0);
        chk("R4 no tick", code, 37);
        ticks(11);
        chk("R3 floor", code, MIN);
        step_cycle(1);
        chk("R3 wrap", code, MAX);
        chk("R8 first wrap", mod_out, 0);
        ticks(13);
        chk("R8 second wrap", mod_out, 1);
        chk("R3 second wrap", code, MAX);

        hs = ~hs; step_cycle(0);
        ticks(5);
        chk("R5 frozen", code, MAX);
        repeat (TO) step_cycle(0);
        step_cycle(1);
        chk("R6 resumed", code, 37);

        carrier = 0;
        ticks(6);
        chk("R7 code held", code, 37);
        chk("R7 modulus held", mod_out, 1);
        carrier = 1;

        fe = 1; fv = 0; step_cycle(1);
        chk("R9 forced", mod_out, 0);
        chk("R9 restart", code, MAX);
        ticks(26);
        chk("R10 no toggle", mod_out, 0);
        chk("R10 sweep runs", code, MAX);
        fe = 0;

        hs = ~hs; step_cycle(0);
        fe = 1; fv = 1; step_cycle(0);
        chk("R9 mod", mod_out, 1);
        step_cycle(1);
        chk("R9 activity cleared", code, 37);
        fe = 0;

        // Constrained random phase compared against the model
        for (int i = 0; i < 4000; i++) begin
            carrier = ($urandom_range(0, 99) < 90);
            tick    = ($urandom_range(0, 99) < 50);
            if ($urandom_range(0, 99) < 2) hs = ~hs;
            fe      = ($urandom_range(0, 99) < 3);
            fv      = 1'($urandom_range(0, 1));
            @(negedge clk);
            chk("R2 R3 R5 R6 R7 R8 R9 R10 code", code, m_code);
            chk("R8 R9 R10 modulus", mod_out, m_mod);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule